// File: doc/BRIEF.md
# Divide-by-Three Processor Clock and Reset Generator

This block turns a fast reference clock into a processor clock at one third of the reference rate, with a one-third high duty cycle, and into a peripheral clock at half the processor clock rate with a 50% duty cycle. The reference can come from either of two feeds. One is an oscillator feed and the other is an external clock feed. A select input chooses between them. The oscillator feed is also repeated on its own output, whatever the select input says, so other logic can use it.

A synchronous clear input, `sync_in`, is sampled on the selected reference. While it is high, the phase counter is cleared and both derived clocks are held high. The first reference rising edge with it low starts a new processor clock cycle. Several generators can be phase-aligned by dropping this input on the same reference edge.

The block also provides a CPU reset output. An active-low reset request is sampled through a short chain of flops. The chain advances only at the reference edges where the processor clock falls. The chain output is inverted and driven as an active-high reset.

Top module: `clkdiv3_rstgen`

## Requirements
- R1: With `sync_in` low, `cpu_clk` repeats a pattern of three selected-reference periods: high for one, then low for two.
- R2: `per_clk` changes state only at reference edges where `cpu_clk` falls, giving half the `cpu_clk` rate at 50% duty. The first such fall after a clear drives `per_clk` low.
- R3: With `src_sel` low, the oscillator feed `osc_in` clocks the block. With it high, the external feed `ext_in` clocks the block. If the selected feed is stopped, all outputs except `osc_out` stay frozen.
- R4: `osc_out` equals `osc_in` at all times, for either value of `src_sel`.
- R5: At every reference edge where `sync_in` is high, the phase counter is cleared and both `cpu_clk` and `per_clk` are driven high.
- R6: The first reference edge with `sync_in` low begins a new `cpu_clk` high phase of exactly one reference period. The next two reference periods are low.
- R7: `rst_out` is the inverse of `rst_req_n` as it was sampled at the previous-but-one `cpu_clk` fall, through two sampling stages. `rst_out` changes only at reference edges where `cpu_clk` falls.
- R8: A reference edge with `sync_in` high clears the sampling stages, so `rst_out` is high during the clear. It stays high until a released request has passed through both stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_in | input | 1 | Oscillator reference feed |
| ext_in | input | 1 | External reference feed |
| src_sel | input | 1 | Reference select: 0 = oscillator feed, 1 = external feed |
| sync_in | input | 1 | Synchronous divider clear, active high |
| rst_req_n | input | 1 | Reset request, active low |
| osc_out | output | 1 | Copy of the oscillator feed |
| cpu_clk | output | 1 | Reference divided by three, one-third high duty |
| per_clk | output | 1 | `cpu_clk` divided by two, 50% duty |
| rst_out | output | 1 | Synchronized reset, active high |

## Verification
A phase counter that skips or repeats a state shows up on `cpu_clk` as a high or low run of the wrong length, within three reference periods. The same fault also breaks the `per_clk` rhythm at the next fall. A toggle flop left in the wrong state after a clear shows up as an inverted `per_clk` at the first `cpu_clk` fall. A sampler with the wrong depth or polarity moves the `rst_out` edge by one `cpu_clk` cycle, or inverts it. This is seen at the second fall after `rst_req_n` changes.

// File: rtl/clkdiv3_pkg.sv
package clkdiv3_pkg;

  // Next phase of a modulo-div counter.
  function automatic int phase_step(input int ph, input int div);
    return (ph >= div - 1) ? 0 : ph + 1;
  endfunction

  // The processor clock is high only during phase zero.
  function automatic logic phase_is_high(input int ph);
    return (ph == 0);
  endfunction

endpackage

// File: rtl/clkdiv3_refmux.sv
module clkdiv3_refmux (
  input  logic osc_i,
  input  logic ext_i,
  input  logic sel_i,
  output logic ref_o,
  output logic osc_o
);

  assign ref_o = sel_i ? ext_i : osc_i;
  assign osc_o = osc_i;

endmodule

// File: rtl/clkdiv3_core.sv
module clkdiv3_core #(
  parameter int DIV_N = 3
) (
  input  logic ref_i,
  input  logic sync_i,
  output logic clk_o,
  output logic fall_o
);
  import clkdiv3_pkg::*;

  localparam int CW = (DIV_N > 2) ? $clog2(DIV_N) : 1;

  logic [CW-1:0] ph_q;
  logic          clk_q;

  always_ff @(posedge ref_i) begin
    if (sync_i) begin
      ph_q  <= '0;
      clk_q <= 1'b1;
    end else begin
      clk_q <= phase_is_high(int'(ph_q));
      ph_q  <= CW'(phase_step(int'(ph_q), DIV_N));
    end
  end

  // Asserted on the reference edge at which the processor clock drops.
  assign fall_o = !sync_i && clk_q && !phase_is_high(int'(ph_q));
  assign clk_o  = clk_q;

  // R1: a free-running high phase lasts one reference period
  p_high_one_r1: assert property (@(posedge ref_i) disable iff (sync_i)
    (clk_q && !$past(sync_i)) |=> !clk_q);

  // R1: the low phase lasts at least two reference periods
  p_low_two_r1: assert property (@(posedge ref_i) disable iff (sync_i)
    ($fell(clk_q) && !$past(sync_i)) |=> !clk_q);

  // R5: clear forces the processor clock high
  p_sync_high_r5: assert property (@(posedge ref_i)
    sync_i |=> clk_q);

endmodule

// File: rtl/clkdiv3_pclk.sv
module clkdiv3_pclk (
  input  logic ref_i,
  input  logic sync_i,
  input  logic fall_i,
  input  logic clk_i,
  output logic pclk_o
);

  logic pclk_q;

  always_ff @(posedge ref_i) begin
    if (sync_i)      pclk_q <= 1'b1;
    else if (fall_i) pclk_q <= ~pclk_q;
  end

  assign pclk_o = pclk_q;

  // R2: the peripheral clock moves only together with a processor clock fall
  p_pclk_on_fall_r2: assert property (@(posedge ref_i) disable iff (sync_i)
    (!$stable(pclk_q) && !$past(sync_i)) |-> $fell(clk_i));

  // R5: clear forces the peripheral clock high
  p_pclk_sync_r5: assert property (@(posedge ref_i)
    sync_i |=> pclk_q);

endmodule

// File: rtl/clkdiv3_rstsync.sv
module clkdiv3_rstsync #(
  parameter int STAGES = 2
) (
  input  logic ref_i,
  input  logic sync_i,
  input  logic fall_i,
  input  logic req_n_i,
  output logic rst_o
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge ref_i) begin
    if (sync_i)      sh_q <= '0;
    else if (fall_i) sh_q <= {sh_q[STAGES-2:0], req_n_i};
  end

  assign rst_o = ~sh_q[STAGES-1];

  // R7: the reset output moves only at a processor clock fall
  p_rst_on_fall_r7: assert property (@(posedge ref_i) disable iff (sync_i)
    (!$stable(rst_o) && !$past(sync_i)) |-> $past(fall_i));

  // R8: clear drives the reset output active
  p_rst_sync_r8: assert property (@(posedge ref_i)
    sync_i |=> rst_o);

endmodule

// File: rtl/clkdiv3_rstgen.sv
module clkdiv3_rstgen #(
  parameter int DIV_N      = 3,
  parameter int RST_STAGES = 2
) (
  input  logic osc_in,
  input  logic ext_in,
  input  logic src_sel,
  input  logic sync_in,
  input  logic rst_req_n,
  output logic osc_out,
  output logic cpu_clk,
  output logic per_clk,
  output logic rst_out
);

  logic ref_clk;
  logic clk_fall;

  clkdiv3_refmux u_mux (
    .osc_i (osc_in),
    .ext_i (ext_in),
    .sel_i (src_sel),
    .ref_o (ref_clk),
    .osc_o (osc_out)
  );

  clkdiv3_core #(.DIV_N(DIV_N)) u_core (
    .ref_i  (ref_clk),
    .sync_i (sync_in),
    .clk_o  (cpu_clk),
    .fall_o (clk_fall)
  );

  clkdiv3_pclk u_pclk (
    .ref_i  (ref_clk),
    .sync_i (sync_in),
    .fall_i (clk_fall),
    .clk_i  (cpu_clk),
    .pclk_o (per_clk)
  );

  clkdiv3_rstsync #(.STAGES(RST_STAGES)) u_rst (
    .ref_i   (ref_clk),
    .sync_i  (sync_in),
    .fall_i  (clk_fall),
    .req_n_i (rst_req_n),
    .rst_o   (rst_out)
  );

endmodule

// File: tb/test_clkdiv3_rstgen.sv
`timescale 1ns/1ps
module test_clkdiv3_rstgen;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic osc_en = 1'b1;
  logic src_sel = 1'b0;
  logic sync_in = 1'b1;
  logic rst_req_n = 1'b0;
  logic osc_in, ext_in;
  logic osc_out, cpu_clk, per_clk, rst_out;

  assign osc_in = clk & osc_en;
  assign ext_in = clk;

  clkdiv3_rstgen i_clkdiv3_rstgen (
    .osc_in    (osc_in),
    .ext_in    (ext_in),
    .src_sel   (src_sel),
    .sync_in   (sync_in),
    .rst_req_n (rst_req_n),
    .osc_out   (osc_out),
    .cpu_clk   (cpu_clk),
    .per_clk   (per_clk),
    .rst_out   (rst_out)
  );

  int checks = 0;
  int errors = 0;
  bit started = 0;
  bit done = 0;
  string phase_tag = "R1";

  // Behavioural reference model
  int   k = 0;
  logic m_clk = 1'b1, m_pclk = 1'b1, m_rst = 1'b1, m_last = 1'b0;
  logic new_clk;

  always @(posedge clk) begin
    if (src_sel || osc_en) begin
      if (sync_in) begin
        k = 0; m_clk = 1'b1; m_pclk = 1'b1; m_last = 1'b0; m_rst = 1'b1;
      end else begin
        k = k + 1;
        new_clk = (k % 3 == 1);
        if (m_clk && !new_clk) begin
          m_pclk = ~m_pclk;
          m_rst  = ~m_last;
          m_last = rst_req_n;
        end
        m_clk = new_clk;
      end
      started = 1;
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (sync_in)
        chk("R5 cpu_clk", cpu_clk, m_clk);
      else if (k >= 1 && k <= 3)
        chk("R6 cpu_clk", cpu_clk, m_clk);
      else
        chk({phase_tag, " cpu_clk"}, cpu_clk, m_clk);
      chk(sync_in ? "R5 per_clk" : "R2 per_clk", per_clk, m_pclk);
      chk(sync_in ? "R8 rst_out" : "R7 rst_out", rst_out, m_rst);
    end
  end

  always @(posedge clk) begin
    #1;
    if (!done) chk("R4 osc_out", osc_out, osc_en);
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    cycles(5);                       // reset state under clear (R5, R8)
    sync_in = 1'b0;                  // R6 restart, R1 steady run
    cycles(40);
    rst_req_n = 1'b1;                // R7 release
    cycles(30);
    rst_req_n = 1'b0;                // R7 short request
    cycles(4);
    rst_req_n = 1'b1;
    cycles(20);
    phase_tag = "R3";                // external feed, oscillator stopped
    src_sel = 1'b1; osc_en = 1'b0;
    cycles(30);
    src_sel = 1'b0;                  // selected feed stopped: frozen (R3)
    cycles(10);
    osc_en = 1'b1;
    cycles(7);
    phase_tag = "R1";
    sync_in = 1'b1;                  // clear in mid-phase (R5, R8)
    cycles(2);
    sync_in = 1'b0;                  // restart (R6)
    cycles(40);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule